// File: doc/BRIEF.md
# Bit-Configurable GPIO Port with Alternate-Function Mux

This block is an 8-bit general-purpose I/O port in which every pin is configured on its own. Software sets each pin's direction, chooses whether it is a plain port pin or is handed to a peripheral, and in the peripheral case picks one of two peripheral output sources. Further per-pin options select open-drain drive, request a pull-up, and enable interrupts on rising edges, falling edges or both.

The pad side carries a driven value, an output enable, an open-drain flag and a pull-up request. Pad inputs pass through a two-flop synchroniser. The synchronised levels can be read back through the register bus and also drive the edge detectors. Configuration is written either as a whole byte or as one bit, using a bit index and a bit value.

Top module: `gpio_port8`

## Requirements
- R1: After reset every configuration register is 00H, so `pad_oe`, `pad_od`, `pad_pu` and `irq` are all 0. A read of code 0 returns 00H while the pins are low.
- R2: A byte write (`wr_en`=1, `wr_bit`=0) loads `wr_data` into the register chosen by `wr_sel`. The register codes are: 0 output latch, 1 direction (1=output), 2 mode (1=control), 3 function (1=function 2), 4 open-drain (1=open-drain), 5 pull-up (1=on), 6 rising-edge enable, 7 falling-edge enable. A read with `rd_sel` equal to any of codes 1 to 7 returns that register.
- R3: A bit write (`wr_en`=1, `wr_bit`=1) sets bit `wr_idx` of the register chosen by `wr_sel` to `wr_val`. All other bits of that register stay unchanged.
- R4: For a push-pull pin (open-drain bit 0), `pad_oe` equals the direction bit.
- R5: The selected output value is the output latch when the mode bit is 0. When the mode bit is 1, it is `alt_a_out` if the function bit is 0 and `alt_b_out` if the function bit is 1. For push-pull pins, `pad_out` carries this value.
- R6: For an open-drain pin, `pad_out` is 0, `pad_oe` is 1 only when the direction bit is 1 and the selected value is 0, and `pad_od` is 1.
- R7: `pad_pu` mirrors the pull-up register.
- R8: A read of code 0 returns the output latch for each bit that is an output in port mode. Every other bit returns the synchronised pin level, which reflects `pad_in` two clock edges after it is sampled.
- R9: A pin edge seen on the synchronised level raises `irq` on that bit for exactly one cycle, two edges after `pad_in` changes. This happens only when the matching rising or falling enable is 1, and both edges are detected when both enables are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_bit | input | 1 | 1 = single-bit write, 0 = byte write |
| wr_sel | input | 3 | Register code for the write |
| wr_data | input | 8 | Byte write data |
| wr_idx | input | 3 | Bit index for a single-bit write |
| wr_val | input | 1 | Bit value for a single-bit write |
| rd_sel | input | 3 | Register code for the read |
| rd_data | output | 8 | Read data (combinational) |
| alt_a_out | input | 8 | Peripheral function 1 output values |
| alt_b_out | input | 8 | Peripheral function 2 output values |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad drive value |
| pad_oe | output | 8 | Pad output enable |
| pad_od | output | 8 | Pad open-drain flag |
| pad_pu | output | 8 | Pad pull-up request |
| pin_sync | output | 8 | Synchronised pin levels for peripherals |
| irq | output | 8 | Per-pin edge interrupt pulses |

## Verification
The assertions assume that `pad_in` may change at any time, but that it is held steady during reset, so no false edge arrives when reset releases. They also assume that `wr_idx` always names a real bit. The bench changes inputs only on falling clock edges, keeps `pad_in` low through reset, and lets the synchroniser settle before it enables edge interrupts. Only small index values go into `wr_idx`.

// File: rtl/gpio_port8.sv
module gpio_port8 #(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_bit,
  input  logic [2:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [IW-1:0] wr_idx,
  input  logic         wr_val,
  input  logic [2:0]   rd_sel,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] alt_a_out,
  input  logic [W-1:0] alt_b_out,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_od,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] pin_sync,
  output logic [W-1:0] irq
);
  logic [W-1:0] cfg [8];
  logic [W-1:0] s1, s2, s3;
  logic [W-1:0] latch_q, dir_q, mode_q, func_q, od_q, pu_q, ren_q, fen_q;
  logic [W-1:0] sel_v, port_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) cfg[i] <= '0;
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      if (wr_en) begin
        if (wr_bit) cfg[wr_sel][wr_idx] <= wr_val;
        else        cfg[wr_sel] <= wr_data;
      end
      s1 <= pad_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign latch_q = cfg[0];
  assign dir_q   = cfg[1];
  assign mode_q  = cfg[2];
  assign func_q  = cfg[3];
  assign od_q    = cfg[4];
  assign pu_q    = cfg[5];
  assign ren_q   = cfg[6];
  assign fen_q   = cfg[7];

  assign sel_v   = (mode_q & ((func_q & alt_b_out) | (~func_q & alt_a_out)))
                 | (~mode_q & latch_q);
  assign pad_out = sel_v & ~od_q;
  assign pad_oe  = dir_q & ~(od_q & sel_v);
  assign pad_od  = od_q;
  assign pad_pu  = pu_q;
  assign pin_sync = s2;
  assign irq     = (s2 & ~s3 & ren_q) | (~s2 & s3 & fen_q);

  assign port_rd = (dir_q & ~mode_q & latch_q) | (~(dir_q & ~mode_q) & s2);
  assign rd_data = (rd_sel == 3'd0) ? port_rd : cfg[rd_sel];
endmodule

module gpio_port8_chk #(parameter int W = 8, localparam int IW = $clog2(W)) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         wr_bit,
  input logic [2:0]   wr_sel,
  input logic [W-1:0] wr_data,
  input logic [IW-1:0] wr_idx,
  input logic [W-1:0] dir,
  input logic [W-1:0] ren,
  input logic [W-1:0] fen,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_od,
  input logic [W-1:0] irq
);
  a_r2_byte_write_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_bit && wr_sel == 3'd1) |=> dir == $past(wr_data));

  a_r3_bit_write_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bit && wr_sel == 3'd1) |=>
      ((dir ^ $past(dir)) & ~(W'(1) << $past(wr_idx))) == '0);

  a_r4_oe_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir) == '0);

  a_r6_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_od & pad_out) == '0);

  a_r9_irq_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~(ren | fen)) == '0);
endmodule

bind gpio_port8 gpio_port8_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit), .wr_sel(wr_sel),
  .wr_data(wr_data), .wr_idx(wr_idx), .dir(dir_q), .ren(ren_q), .fen(fen_q),
  .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .irq(irq)
);

// File: tb/gpio_port8_test.sv
module gpio_port8_test;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_bit = 0, wr_val = 0;
  logic [2:0] wr_sel = 0, rd_sel = 0, wr_idx = 0;
  logic [7:0] wr_data = 0, alt_a_out = 0, alt_b_out = 0, pad_in = 0;
  logic [7:0] rd_data, pad_out, pad_oe, pad_od, pad_pu, pin_sync, irq;
  int runs = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  gpio_port8 uut (.*);

  typedef struct packed {
    logic [7:0] latch, dir, mode, func, od, a, b, e_out, e_oe;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{8'hA5, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hA5, 8'hFF},
    '{8'h00, 8'hF0, 8'hFF, 8'h0F, 8'h00, 8'h3C, 8'hC3, 8'h33, 8'hF0},
    '{8'h0F, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hF0},
    '{8'hAA, 8'h0F, 8'hF0, 8'hC0, 8'h0C, 8'hFF, 8'h00, 8'h32, 8'h07}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wbyte(logic [2:0] s, logic [7:0] d);
    wr_en = 1; wr_bit = 0; wr_sel = s; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wbit(logic [2:0] s, logic [2:0] i, logic v);
    wr_en = 1; wr_bit = 1; wr_sel = s; wr_idx = i; wr_val = v;
    @(posedge clk); @(negedge clk);
    wr_en = 0; wr_bit = 0;
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    check("R1 oe", pad_oe, 8'h00);
    check("R1 od", pad_od, 8'h00);
    check("R1 pu", pad_pu, 8'h00);
    check("R1 irq", irq, 8'h00);
    rd_sel = 0; #1 check("R1 rd", rd_data, 8'h00);

    // R4 R5 R6 output mux vectors
    for (int k = 0; k < 4; k++) begin
      wbyte(3'd0, VECS[k].latch);
      wbyte(3'd1, VECS[k].dir);
      wbyte(3'd2, VECS[k].mode);
      wbyte(3'd3, VECS[k].func);
      wbyte(3'd4, VECS[k].od);
      alt_a_out = VECS[k].a; alt_b_out = VECS[k].b;
      #1;
      check("R5 R6 pad_out", pad_out, VECS[k].e_out);
      check("R4 R6 pad_oe", pad_oe, VECS[k].e_oe);
      check("R6 pad_od", pad_od, VECS[k].od);
    end

    // R2 readback
    for (int s = 1; s < 8; s++) begin
      wbyte(3'(s), 8'h11 * s[7:0] ^ 8'h5A);
      rd_sel = 3'(s); #1;
      check("R2 readback", rd_data, 8'h11 * s[7:0] ^ 8'h5A);
    end

    // R3 R7 bit writes
    wbyte(3'd5, 8'hF0);
    wbit(3'd5, 3'd1, 1'b1);
    check("R3 R7 set bit", pad_pu, 8'hF2);
    wbit(3'd5, 3'd7, 1'b0);
    check("R3 R7 clear bit", pad_pu, 8'h72);
    rd_sel = 3'd5; #1 check("R3 readback", rd_data, 8'h72);

    // R8 port read
    wbyte(3'd6, 8'h00); wbyte(3'd7, 8'h00);
    wbyte(3'd2, 8'h00); wbyte(3'd4, 8'h00);
    wbyte(3'd1, 8'h0F); wbyte(3'd0, 8'h05);
    rd_sel = 3'd0;
    pad_in = 8'hA0;
    tick(1);
    check("R8 one edge", rd_data, 8'h05);
    tick(1);
    check("R8 two edges", rd_data, 8'hA5);
    wbyte(3'd2, 8'h01);
    check("R8 control mode reads pin", rd_data, 8'hA4);

    // R9 edge interrupts
    pad_in = 8'h00; tick(4);
    wbyte(3'd6, 8'h05); wbyte(3'd7, 8'h06);
    pad_in = 8'h0F;
    tick(1); check("R9 rise latency", irq, 8'h00);
    tick(1); check("R9 rise pulse", irq, 8'h05);
    tick(1); check("R9 rise one cycle", irq, 8'h00);
    pad_in = 8'h00;
    tick(2); check("R9 fall pulse", irq, 8'h06);
    tick(1); check("R9 fall one cycle", irq, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule